// File: doc/BRIEF.md
# Fully Associative Address Translation Cache with Recency Ranks

This block holds a small set of recent virtual-to-physical page mappings and translates 16-bit virtual addresses, which use 256-byte pages, in the same cycle. Every stored entry is compared with the requested page number at once. A match returns the physical address, checks the access against the entry's permission bits, and on a permitted write marks the page as modified. A request that matches nothing is reported as a miss. The miss handler then supplies the mapping through the fill port.

Each entry carries a 3-bit recency rank that records its place in the full access order. Rank 0 is the newest access and rank 7 is the oldest. An empty entry always sits at rank 7, so a fill goes to the first empty slot while one exists and to the oldest entry after that. The flush input discards every mapping, for example when the page-table base changes.

Top module: `xlate_cache`

## Requirements
- R1: The page number is `req_vaddr[15:8]` and the page offset is `req_vaddr[7:0]`. In the same cycle as a hit, `paddr` is the entry's physical page number concatenated with the request's offset.
- R2: When `req_valid` is high, `hit` rises if a valid entry's tag equals the page number, and otherwise `miss` rises. When `req_valid` is low, both `hit` and `miss` are low.
- R3: Permission bit 0 allows reads and bit 1 allows writes. A hit whose access type is not allowed raises `prot_fault` together with `hit`. Such a hit changes neither the dirty bit nor any rank.
- R4: A permitted write hit sets the entry's dirty bit. On every hit, `hit_dirty` shows the dirty bit the matched entry holds before that cycle's update.
- R5: On a permitted hit or on a fill, the touched entry takes rank 0. Every entry whose rank was below the touched entry's old rank moves up by one. All other ranks stay unchanged.
- R6: A fill writes the tag, physical page number, permission bits and dirty bit into a victim slot and marks it valid. The victim is the lowest-indexed invalid entry, or the entry ranked 7 when all entries are valid.
- R7: `flush` clears every valid bit and sets every rank to 7. It takes priority over a fill and a hit in the same cycle.
- R8: When a fill and a request arrive in the same cycle, the request's outputs are still produced. The fill updates the state, and the request changes neither a rank nor a dirty bit.
- R9: After reset, all entries are invalid, so every request misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Translation request present |
| req_write | input | 1 | Request is a write (0 = read) |
| req_vaddr | input | 16 | Virtual address to translate |
| hit | output | 1 | Page number found in a valid entry |
| miss | output | 1 | Request found no valid entry |
| prot_fault | output | 1 | Hit, but the access type is forbidden |
| hit_dirty | output | 1 | Dirty bit of the matched entry |
| paddr | output | 16 | Translated physical address |
| fill_valid | input | 1 | Write a new entry this cycle |
| fill_vpn | input | 8 | Tag of the new entry |
| fill_ppn | input | 8 | Physical page number of the new entry |
| fill_perm | input | 2 | Permissions of the new entry (bit0 read, bit1 write) |
| fill_dirty | input | 1 | Initial dirty bit of the new entry |

## Verification
The bench builds the block with its default parameters: 16-bit addresses, an 8-bit offset, 8-bit physical pages and 8 entries. With only eight slots and a 3-bit rank, directed sequences can fill the whole cache and then evict each entry in turn, so the rank-7 victim choice is exercised directly. A random phase draws page numbers from a range only slightly larger than the cache, which keeps hits, misses, evictions, flushes and same-cycle collisions between fills and requests all frequent.

// File: rtl/xlate_cache.sv
module xlate_cache #(
  parameter int ADDR_W  = 16,
  parameter int OFF_W   = 8,
  parameter int PPN_W   = 8,
  parameter int ENTRIES = 8,
  parameter int PERM_W  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_vaddr,
  output logic                   hit,
  output logic                   miss,
  output logic                   prot_fault,
  output logic                   hit_dirty,
  output logic [PPN_W+OFF_W-1:0] paddr,
  input  logic                   fill_valid,
  input  logic [ADDR_W-OFF_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0]       fill_ppn,
  input  logic [PERM_W-1:0]      fill_perm,
  input  logic                   fill_dirty
);
  localparam int VPN_W = ADDR_W - OFF_W;
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] valid, dirty, match;
  logic [VPN_W-1:0]   tag  [ENTRIES];
  logic [PPN_W-1:0]   ppn  [ENTRIES];
  logic [PERM_W-1:0]  perm [ENTRIES];
  logic [IDX_W-1:0]   rank [ENTRIES];

  logic [VPN_W-1:0] vpn;
  logic [IDX_W-1:0] hit_idx, victim, touch_idx, old_rank;
  logic             found, perm_ok, upd_hit, touch_en;

  assign vpn = req_vaddr[ADDR_W-1:OFF_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid[g] && (tag[g] == vpn);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) hit_idx = IDX_W'(i);
  end

  always_comb begin
    victim = '0;
    found  = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid[i]) begin
        victim = IDX_W'(i);
        found  = 1'b1;
      end
    if (!found)
      for (int i = 0; i < ENTRIES; i++)
        if (rank[i] == OLDEST) victim = IDX_W'(i);
  end

  assign perm_ok    = req_write ? perm[hit_idx][1] : perm[hit_idx][0];
  assign hit        = req_valid && (|match);
  assign miss       = req_valid && !(|match);
  assign prot_fault = hit && !perm_ok;
  assign hit_dirty  = hit && dirty[hit_idx];
  assign paddr      = {ppn[hit_idx], req_vaddr[OFF_W-1:0]};

  assign upd_hit   = !flush && !fill_valid && hit && perm_ok;
  assign touch_en  = !flush && (fill_valid || upd_hit);
  assign touch_idx = fill_valid ? victim : hit_idx;
  assign old_rank  = rank[touch_idx];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      valid <= '0;
      for (int i = 0; i < ENTRIES; i++) rank[i] <= OLDEST;
      if (!rst_n) begin
        dirty <= '0;
        for (int i = 0; i < ENTRIES; i++) begin
          tag[i]  <= '0;
          ppn[i]  <= '0;
          perm[i] <= '0;
        end
      end
    end else begin
      if (touch_en)
        for (int i = 0; i < ENTRIES; i++)
          if (IDX_W'(i) == touch_idx)   rank[i] <= '0;
          else if (rank[i] < old_rank) rank[i] <= rank[i] + 1'b1;
      if (fill_valid) begin
        valid[victim] <= 1'b1;
        dirty[victim] <= fill_dirty;
        tag[victim]   <= fill_vpn;
        ppn[victim]   <= fill_ppn;
        perm[victim]  <= fill_perm;
      end else if (upd_hit && req_write) begin
        dirty[hit_idx] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/xlate_cache_props.sv
module xlate_cache_props #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 8,
  parameter int PPN_W  = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   flush,
  input logic                   req_valid,
  input logic [ADDR_W-1:0]      req_vaddr,
  input logic                   hit,
  input logic                   miss,
  input logic                   prot_fault,
  input logic [PPN_W+OFF_W-1:0] paddr
);
  assert_hit_miss_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && miss));
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !hit && !miss);
  assert_fault_needs_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    prot_fault |-> hit);
  assert_offset_passes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> paddr[OFF_W-1:0] == req_vaddr[OFF_W-1:0]);
  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !hit);
endmodule

bind xlate_cache xlate_cache_props #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .PPN_W(PPN_W)) u_props (
  .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
  .req_vaddr(req_vaddr), .hit(hit), .miss(miss), .prot_fault(prot_fault),
  .paddr(paddr)
);

// File: tb/xlate_cache_bench.sv
module xlate_cache_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic flush = 0, req_valid = 0, req_write = 0, fill_valid = 0, fill_dirty = 0;
  logic [15:0] req_vaddr = '0;
  logic [7:0]  fill_vpn = '0, fill_ppn = '0;
  logic [1:0]  fill_perm = '0;
  logic hit, miss, prot_fault, hit_dirty;
  logic [15:0] paddr;

  int errors = 0, checks = 0;
  int m_valid[8], m_dirty[8], m_tag[8], m_ppn[8], m_perm[8], m_rank[8];

  always #10 clk = ~clk;

  xlate_cache u_xlate_cache (
    .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
    .req_write(req_write), .req_vaddr(req_vaddr), .hit(hit), .miss(miss),
    .prot_fault(prot_fault), .hit_dirty(hit_dirty), .paddr(paddr),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_perm(fill_perm), .fill_dirty(fill_dirty)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int find(int vpn);
    for (int i = 0; i < 8; i++) if (m_valid[i] != 0 && m_tag[i] == vpn) return i;
    return -1;
  endfunction

  function automatic int pick_victim();
    for (int i = 0; i < 8; i++) if (m_valid[i] == 0) return i;
    for (int i = 0; i < 8; i++) if (m_rank[i] == 7) return i;
    return 0;
  endfunction

  task automatic touch(int t);
    int old = m_rank[t];
    for (int i = 0; i < 8; i++)
      if (i == t) m_rank[i] = 0;
      else if (m_rank[i] < old) m_rank[i]++;
  endtask

  task automatic op(string tag, bit fl, bit rv, bit rw, int va,
                    bit fv, int fvpn, int fppn, int fperm, bit fd);
    int m, ok, v;
    @(negedge clk);
    flush = fl; req_valid = rv; req_write = rw; req_vaddr = 16'(va);
    fill_valid = fv; fill_vpn = 8'(fvpn); fill_ppn = 8'(fppn);
    fill_perm = 2'(fperm); fill_dirty = fd;
    #5;
    m = find((va >> 8) & 255);
    ok = (m >= 0) ? (rw ? (m_perm[m] >> 1) & 1 : m_perm[m] & 1) : 0;
    chk(tag, "hit", int'(hit), (rv && m >= 0) ? 1 : 0);
    chk(tag, "miss", int'(miss), (rv && m < 0) ? 1 : 0);
    chk(tag, "prot_fault", int'(prot_fault), (rv && m >= 0 && ok == 0) ? 1 : 0);
    if (rv && m >= 0) begin
      chk(tag, "hit_dirty", int'(hit_dirty), m_dirty[m]);
      chk(tag, "paddr", int'(paddr), (m_ppn[m] << 8) | (va & 255));
    end
    if (fl) begin
      for (int i = 0; i < 8; i++) begin m_valid[i] = 0; m_rank[i] = 7; end
    end else if (fv) begin
      v = pick_victim();
      touch(v);
      m_valid[v] = 1; m_tag[v] = fvpn; m_ppn[v] = fppn; m_perm[v] = fperm; m_dirty[v] = fd;
    end else if (rv && m >= 0 && ok != 0) begin
      touch(m);
      if (rw) m_dirty[m] = 1;
    end
  endtask

  task automatic rd(string tag, int va);  op(tag, 0, 1, 0, va, 0, 0, 0, 0, 0); endtask
  task automatic wr(string tag, int va);  op(tag, 0, 1, 1, va, 0, 0, 0, 0, 0); endtask
  task automatic fill(string tag, int vpn, int pp, int pm, bit d);
    op(tag, 0, 0, 0, 0, 1, vpn, pp, pm, d);
  endtask

  initial begin
    #3_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_valid[i] = 0; m_dirty[i] = 0; m_tag[i] = 0; m_ppn[i] = 0; m_perm[i] = 0; m_rank[i] = 7;
    end
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd("R9", 16'h1234);
    wr("R9", 16'h0000);
    for (int i = 0; i < 8; i++)
      fill("R6", 8'h10 + i, 8'h80 + i, (i == 3) ? 1 : (i == 4) ? 2 : 3, i == 6);
    for (int i = 0; i < 8; i++) rd("R1", ((8'h10 + i) << 8) | (i * 37 + 5));
    rd("R2", 16'h2a00);
    op("R2", 0, 0, 0, 16'h1000, 0, 0, 0, 0, 0);
    wr("R3", 16'h1301);
    rd("R3", 16'h1477);
    wr("R3", 16'h1478);
    rd("R3", 16'h1302);
    wr("R4", 16'h1201);
    rd("R4", 16'h12fe);
    rd("R4", 16'h16aa);
    rd("R5", 16'h1100); rd("R5", 16'h1500);
    fill("R6", 8'h20, 8'h40, 3, 0);
    fill("R6", 8'h21, 8'h41, 3, 1);
    for (int i = 0; i < 8; i++) rd("R5", ((8'h10 + i) << 8) | 8'h33);
    rd("R6", 16'h2000); rd("R6", 16'h2100);
    op("R8", 0, 1, 1, 16'h1010, 1, 8'h30, 8'h50, 1, 0);
    rd("R8", 16'h1011); rd("R8", 16'h3012);
    op("R7", 1, 1, 0, 16'h2000, 1, 8'h31, 8'h51, 3, 0);
    rd("R7", 16'h2000); rd("R7", 16'h3100); rd("R7", 16'h1500);
    fill("R7", 8'h44, 8'h60, 3, 0);
    rd("R7", 16'h4400);
    for (int n = 0; n < 2000; n++) begin
      int r = $urandom_range(0, 99);
      int vp = 8'h10 + $urandom_range(0, 11);
      int va = (vp << 8) | $urandom_range(0, 255);
      if (r < 2) op("R7", 1, 1, 0, va, 0, 0, 0, 0, 0);
      else if (r < 20 && find(vp) < 0)
        op("R8", 0, $urandom_range(0, 1), $urandom_range(0, 1), va, 1, vp,
           $urandom_range(0, 255), $urandom_range(0, 3), $urandom_range(0, 1));
      else op("R5", 0, 1, $urandom_range(0, 1), va, 0, 0, 0, 0, 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule